// File: doc/BRIEF.md
# Six-Mode 32-bit Down-Counting Timer Channel

This block is one programmable timer channel. A 32-bit counter decrements on every system clock cycle in which the count-enable tick is high. A gate input and an output line interact with it in one of six behaviours picked by a 3-bit mode code:

- event on terminal count
- gate-started single pulse that a new gate edge can retrigger
- periodic rate strobe
- square wave
- software-started strobe
- gate-started strobe

Software writes the mode and an initial count through two write strobes. Each mode has its own rule for what the gate level or gate rising edge does, and for when a freshly written count takes effect.

A chip-level timer unit places several of these channels side by side, each with its own tick, gate and output. Read-back of the running count and any register decoding belong to that wrapper. All state changes on the rising edge of `clk`. Counting steps happen only on edges where `tick_i` is high. Writes act on the edge where their strobe is high, whatever the tick is doing.

Top module: `ctr_dn_chan`

## Requirements
- R1: After reset the channel is in mode 0 with no count loaded and `out_o` low, and it stays low while no count is written.
- R2: Mode 0: a count write N drives `out_o` low on the write edge, and `out_o` rises on the N-th counting edge after it. It then stays high until the next count or mode write.
- R3: Mode 0: counting steps only on edges where `gate_i` is high, and a count write made mid-count restarts the countdown from the new value at once.
- R4: Mode 1: a count write alone leaves `out_o` high. A `gate_i` rising edge loads N and drives `out_o` low, and `out_o` returns high on the N-th counting edge after that. A new rising edge during the pulse reloads N and lengthens the pulse.
- R5: Modes 1 and 5: a count written while a countdown runs does not alter that countdown, and it is used by the next `gate_i` rising edge.
- R6: Mode 2: once a count N is written (with `gate_i` high), `out_o` is low for exactly one counting edge out of every N, first on the N-th counting edge after the write.
- R7: Mode 3: `out_o` is high for (N+1)/2 counting edges and low for N/2 (integer division), so even N gives equal halves and odd N a longer high half.
- R8: Modes 2 and 3: while `gate_i` is low, the count and `out_o` hold. A count written while running takes effect at the next reload point, not mid-period.
- R9: Mode 4: a count write starts counting at once (while `gate_i` is high), `out_o` goes low for one counting edge on the N-th edge, and it fires only once. A rewrite mid-count restarts from the new value.
- R10: Mode 5: a count write alone produces no strobe. N counting edges after a `gate_i` rising edge, `out_o` goes low for one counting edge.
- R11: A mode write stops the counter and sets `out_o` low for mode 0 and high for any other mode. Codes 6 and 7 behave as modes 2 and 3. A mode write in the same cycle as a count write discards the count write.
- R12: On edges where `tick_i` is low, the count does not step in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable; one counting step per high cycle |
| gate_i | input | 1 | Gate input, level and rising edge used per mode |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_sel_i | input | 3 | Mode code 0..7 (6 and 7 alias 2 and 3) |
| count_wr_i | input | 1 | Initial-count write strobe |
| count_val_i | input | 32 | Initial count N |
| out_o | output | 1 | Timer output line |

## Verification
On every cycle the embedded assertions check these local rules:

- the terminal-count output holding high in mode 0
- a mode 1 gate edge pulling the output low
- strobes in modes 2, 4 and 5 lasting a single counting edge
- the gate-low freeze of modes 2 and 3
- the count holding when the tick is low

The directed scenarios cover what spans many cycles. They measure whole periods and duty splits for several N, time a retriggered pulse against its unstretched length, and show that a count written mid-run waits for the next gate edge or reload point. They also confirm the mode-code aliases and the write-priority rule.

// File: rtl/ctr_dn_pkg.sv
package ctr_dn_pkg;

    typedef enum logic [2:0] {
        M_TC_EVENT = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SW_STB   = 3'd4,
        M_HW_STB   = 3'd5
    } ctr_mode_e;

    function automatic ctr_mode_e decode_mode(input logic [2:0] code);
        ctr_mode_e m;
        case (code)
            3'd0:    m = M_TC_EVENT;
            3'd1:    m = M_ONESHOT;
            3'd2:    m = M_RATE;
            3'd3:    m = M_SQUARE;
            3'd4:    m = M_SW_STB;
            3'd5:    m = M_HW_STB;
            3'd6:    m = M_RATE;
            default: m = M_SQUARE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ctr_gate_edge.sv
module ctr_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_d, gate_q;

    always_comb gate_d = gate_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate_d;
    end

    assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/ctr_decr.sv
module ctr_decr #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cnt_m1_o,
    output logic             at_one_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        cnt_m1_o = cnt_i - ONE;
        at_one_o = (cnt_i == ONE);
    end
endmodule

// File: rtl/ctr_half_len.sv
module ctr_half_len #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] n_i,
    output logic [CNT_W-1:0] hi_o,
    output logic [CNT_W-1:0] lo_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] hi_raw;

    always_comb begin
        half   = n_i >> 1;
        hi_raw = half + {{(CNT_W-1){1'b0}}, n_i[0]};
        hi_o   = (hi_raw == '0) ? ONE : hi_raw;
        lo_o   = (half == '0)   ? ONE : half;
    end
endmodule

// File: rtl/ctr_dn_chan.sv
module ctr_dn_chan
    import ctr_dn_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             gate_i,
    input  logic             mode_wr_i,
    input  logic [2:0]       mode_sel_i,
    input  logic             count_wr_i,
    input  logic [CNT_W-1:0] count_val_i,
    output logic             out_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        ctr_mode_e        mode;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic             out;
        logic             run;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic             rise_w;
    logic [CNT_W-1:0] cnt_m1_w;
    logic             at_one_w;
    logic [CNT_W-1:0] load_src_w;
    logic [CNT_W-1:0] hi_w, lo_w;
    ctr_mode_e        new_mode_w;
    logic             step_w;

    ctr_gate_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (gate_i),
        .rise_o (rise_w)
    );

    ctr_decr #(.CNT_W(CNT_W)) u_decr (
        .cnt_i    (st_q.count),
        .cnt_m1_o (cnt_m1_w),
        .at_one_o (at_one_w)
    );

    assign load_src_w = count_wr_i ? count_val_i : st_q.reload;

    ctr_half_len #(.CNT_W(CNT_W)) u_half (
        .n_i  (load_src_w),
        .hi_o (hi_w),
        .lo_o (lo_w)
    );

    always_comb begin
        st_d       = st_q;
        new_mode_w = decode_mode(mode_sel_i);
        step_w     = st_q.run & tick_i;

        if (mode_wr_i) begin
            st_d.mode = new_mode_w;
            st_d.run  = 1'b0;
            st_d.out  = (new_mode_w != M_TC_EVENT);
        end else begin
            case (st_q.mode)
                M_TC_EVENT: begin
                    if (count_wr_i) begin
                        st_d.count = count_val_i;
                        st_d.out   = 1'b0;
                        st_d.run   = 1'b1;
                    end else if (step_w && gate_i) begin
                        if (at_one_w) begin
                            st_d.count = '0;
                            st_d.out   = 1'b1;
                            st_d.run   = 1'b0;
                        end else begin
                            st_d.count = cnt_m1_w;
                        end
                    end
                end

                M_ONESHOT, M_HW_STB: begin
                    if (st_q.mode == M_HW_STB && tick_i && !st_q.out)
                        st_d.out = 1'b1;
                    if (count_wr_i)
                        st_d.reload = count_val_i;
                    if (rise_w) begin
                        st_d.count = load_src_w;
                        st_d.run   = 1'b1;
                        st_d.out   = (st_q.mode == M_HW_STB);
                    end else if (step_w) begin
                        if (at_one_w) begin
                            st_d.count = '0;
                            st_d.run   = 1'b0;
                            st_d.out   = (st_q.mode == M_ONESHOT);
                        end else begin
                            st_d.count = cnt_m1_w;
                        end
                    end
                end

                M_RATE: begin
                    if (count_wr_i)
                        st_d.reload = count_val_i;
                    if (count_wr_i && !st_q.run) begin
                        st_d.count = count_val_i;
                        st_d.out   = 1'b1;
                        st_d.run   = 1'b1;
                    end else if (step_w && gate_i) begin
                        if (at_one_w) begin
                            st_d.count = load_src_w;
                            st_d.out   = 1'b0;
                        end else begin
                            st_d.count = cnt_m1_w;
                            st_d.out   = 1'b1;
                        end
                    end
                end

                M_SQUARE: begin
                    if (count_wr_i)
                        st_d.reload = count_val_i;
                    if (count_wr_i && !st_q.run) begin
                        st_d.count = hi_w;
                        st_d.out   = 1'b1;
                        st_d.run   = 1'b1;
                    end else if (step_w && gate_i) begin
                        if (at_one_w) begin
                            st_d.out   = ~st_q.out;
                            st_d.count = st_q.out ? lo_w : hi_w;
                        end else begin
                            st_d.count = cnt_m1_w;
                        end
                    end
                end

                M_SW_STB: begin
                    if (count_wr_i) begin
                        st_d.count = count_val_i;
                        st_d.run   = 1'b1;
                        st_d.out   = 1'b1;
                    end else begin
                        if (tick_i && !st_q.out)
                            st_d.out = 1'b1;
                        if (step_w && gate_i) begin
                            if (at_one_w) begin
                                st_d.count = '0;
                                st_d.run   = 1'b0;
                                st_d.out   = 1'b0;
                            end else begin
                                st_d.count = cnt_m1_w;
                            end
                        end
                    end
                end

                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= M_TC_EVENT;
            st_q.count  <= '0;
            st_q.reload <= '0;
            st_q.out    <= 1'b0;
            st_q.run    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    AST_TC_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_TC_EVENT && st_q.out && !mode_wr_i && !count_wr_i) |=> st_q.out); // R2

    AST_ONESHOT_TRIG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_ONESHOT && rise_w && !mode_wr_i) |=> !st_q.out); // R4

    AST_RATE_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_RATE && !st_q.out && st_q.run && tick_i && gate_i && !mode_wr_i
         && st_q.reload > ONE && !count_wr_i) |=> st_q.out); // R6

    AST_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_SW_STB || st_q.mode == M_HW_STB) && !st_q.out && tick_i && !mode_wr_i)
        |=> st_q.out); // R9

    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_RATE || st_q.mode == M_SQUARE) && st_q.run && !gate_i
         && !mode_wr_i && !count_wr_i) |=> ($stable(st_q.count) && $stable(st_q.out))); // R8

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !mode_wr_i && !count_wr_i && !rise_w) |=> $stable(st_q.count)); // R12

endmodule

// File: tb/ctr_dn_chan_tb.sv
`timescale 1ns/1ps
module ctr_dn_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        gate_i = 1'b1;
    logic        mode_wr_i = 1'b0;
    logic [2:0]  mode_sel_i = 3'd0;
    logic        count_wr_i = 1'b0;
    logic [31:0] count_val_i = '0;
    logic        out_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ctr_dn_chan u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i),
        .mode_wr_i(mode_wr_i), .mode_sel_i(mode_sel_i),
        .count_wr_i(count_wr_i), .count_val_i(count_val_i), .out_o(out_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [2:0] m);
        mode_wr_i = 1'b1; mode_sel_i = m;
        step(1);
        mode_wr_i = 1'b0;
    endtask

    task automatic wr_cnt(input logic [31:0] v);
        count_wr_i = 1'b1; count_val_i = v;
        step(1);
        count_wr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 out after reset", out_o, 0);
        step(5);
        check("R1 out idle", out_o, 0);
    endtask

    task automatic t_mode0();
        gate_i = 1'b1; tick_i = 1'b1;
        set_mode(3'd0);
        check("R11 mode0 out low", out_o, 0);
        wr_cnt(5);
        check("R2 low on write", out_o, 0);
        step(4); check("R2 before tc", out_o, 0);
        step(1); check("R2 at tc", out_o, 1);
        step(6); check("R2 holds high", out_o, 1);
        wr_cnt(10); step(3);
        wr_cnt(4);
        step(3); check("R3 rewrite low", out_o, 0);
        step(1); check("R3 rewrite tc", out_o, 1);
        gate_i = 1'b0;
        wr_cnt(3); step(10);
        check("R3 gate low holds", out_o, 0);
        gate_i = 1'b1;
        step(2); check("R3 gate resumed", out_o, 0);
        step(1); check("R3 gate tc", out_o, 1);
    endtask

    task automatic t_tick();
        tick_i = 1'b0;
        wr_cnt(2); step(8);
        check("R12 no tick no count", out_o, 0);
        tick_i = 1'b1;
        step(1); check("R12 first tick", out_o, 0);
        step(1); check("R12 second tick", out_o, 1);
    endtask

    task automatic t_priority();
        mode_wr_i = 1'b1; mode_sel_i = 3'd0;
        count_wr_i = 1'b1; count_val_i = 32'd2;
        step(1);
        mode_wr_i = 1'b0; count_wr_i = 1'b0;
        check("R11 mode write low", out_o, 0);
        step(6);
        check("R11 count write dropped", out_o, 0);
    endtask

    task automatic t_mode1();
        gate_i = 1'b0;
        set_mode(3'd1);
        check("R11 mode1 out high", out_o, 1);
        wr_cnt(3); step(4);
        check("R4 write alone idle", out_o, 1);
        gate_i = 1'b1; step(1);
        check("R4 low on rise", out_o, 0);
        step(2); check("R4 still low", out_o, 0);
        step(1); check("R4 high at N", out_o, 1);
        gate_i = 1'b0; step(1);
        gate_i = 1'b1; step(1);
        step(1);
        gate_i = 1'b0; step(1);
        gate_i = 1'b1; step(1);
        check("R4 retrigger stretched", out_o, 0);
        step(2); check("R4 stretched low", out_o, 0);
        step(1); check("R4 stretched end", out_o, 1);
        gate_i = 1'b0; step(1);
        gate_i = 1'b1; step(1);
        wr_cnt(8);
        step(1); check("R5 old run low", out_o, 0);
        step(1); check("R5 old N kept", out_o, 1);
        gate_i = 1'b0; step(1);
        gate_i = 1'b1; step(1);
        step(7); check("R5 new N low", out_o, 0);
        step(1); check("R5 new N end", out_o, 1);
    endtask

    task automatic t_mode5();
        gate_i = 1'b0;
        set_mode(3'd5);
        wr_cnt(4); step(6);
        check("R10 no strobe on write", out_o, 1);
        gate_i = 1'b1; step(1);
        check("R10 high after rise", out_o, 1);
        step(3); check("R10 before strobe", out_o, 1);
        step(1); check("R10 strobe", out_o, 0);
        step(1); check("R10 strobe one edge", out_o, 1);
        step(5); check("R10 stays high", out_o, 1);
    endtask

    task automatic t_mode2();
        int lows = 0;
        int first = 0;
        gate_i = 1'b1;
        set_mode(3'd2);
        wr_cnt(4);
        for (int i = 1; i <= 12; i++) begin
            step(1);
            if (out_o == 1'b0) begin
                lows++;
                if (first == 0) first = i;
            end
        end
        check("R6 lows per 12", lows, 3);
        check("R6 first low", first, 4);
        set_mode(3'd2);
        wr_cnt(4); step(1);
        wr_cnt(6);
        step(1); check("R8 old period", out_o, 1);
        step(1); check("R8 reload edge", out_o, 0);
        step(5); check("R8 new period high", out_o, 1);
        step(1); check("R8 new period low", out_o, 0);
        gate_i = 1'b0; step(5);
        check("R8 gate low holds", out_o, 0);
        gate_i = 1'b1; step(1);
        check("R8 gate resumes", out_o, 1);
        set_mode(3'd6);
        wr_cnt(3);
        step(2); check("R11 code6 high", out_o, 1);
        step(1); check("R11 code6 strobe", out_o, 0);
    endtask

    task automatic t_square(input logic [2:0] m, input int n, input string req);
        int lo_run = 0;
        int hi_run = 0;
        int guard = 0;
        gate_i = 1'b1;
        set_mode(m);
        wr_cnt(n);
        while (out_o != 1'b0 && guard < 4 * n) begin step(1); guard++; end
        while (out_o == 1'b0 && lo_run < 4 * n) begin step(1); lo_run++; end
        while (out_o == 1'b1 && hi_run < 4 * n) begin step(1); hi_run++; end
        check({req, " low half"}, lo_run, n / 2);
        check({req, " high half"}, hi_run, (n + 1) / 2);
    endtask

    task automatic t_sq_gate();
        gate_i = 1'b1;
        set_mode(3'd3);
        wr_cnt(10); step(2);
        gate_i = 1'b0; step(8);
        check("R8 square frozen", out_o, 1);
        gate_i = 1'b1;
        step(2); check("R8 square resumed", out_o, 1);
        step(1); check("R8 square toggle", out_o, 0);
    endtask

    task automatic t_mode4();
        gate_i = 1'b1;
        set_mode(3'd4);
        wr_cnt(3);
        step(2); check("R9 before strobe", out_o, 1);
        step(1); check("R9 strobe", out_o, 0);
        step(1); check("R9 strobe one edge", out_o, 1);
        step(8); check("R9 only once", out_o, 1);
        wr_cnt(6); step(1);
        wr_cnt(5);
        step(4); check("R9 restart pending", out_o, 1);
        step(1); check("R9 restart strobe", out_o, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_mode0();
        t_tick();
        t_priority();
        t_mode1();
        t_mode5();
        t_mode2();
        t_square(3'd3, 5, "R7 N=5");
        t_square(3'd3, 6, "R7 N=6");
        t_square(3'd3, 7, "R7 N=7");
        t_square(3'd7, 4, "R11 code7");
        t_sq_gate();
        t_mode4();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run did not end)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule